// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a word of level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request and a fast request. The raw level word is shared. Each output has its own enable mask and is driven high whenever any enabled line is active. Software never writes a mask directly. It changes a mask through a write-one-to-set port and a write-one-to-clear port, so that independent drivers can claim or release their own lines without a read-modify-write sequence.

Bit 0 of the level word is shared between input line 0 and a software-controlled request latch. Software can set the latch to raise an interrupt from code, and later clear it. A simple word-indexed register bus gives software access to the masked status, the raw level and the mask readback of each output. The bus has no wait states, and read data is returned in the same cycle as the select. Accesses that the register map does not permit raise a one-cycle error flag.

Top module: `dual_line_intc`

## Requirements
- R1: During and immediately after reset, both enable masks are zero, the software latch is low, and `irq_o`, `fiq_o` and `bad_o` are low.
- R2: A write to word index 2 ORs the write data into the normal-request mask. A write to index 3 clears each mask bit whose write data bit is 1. A read of index 2 returns the mask.
- R3: Indexes 10 and 11 set and clear the fast-request mask in the same way. A read of index 10 returns that mask.
- R4: Reads of index 1 and of index 9 both return the raw level word. In that word, bit n follows input line n, and bit 0 is input line 0 ORed with the software latch.
- R5: A read of index 0 returns the raw level ANDed with the normal-request mask. A read of index 8 returns the raw level ANDed with the fast-request mask.
- R6: A write to index 4 with data bit 0 set raises the software latch. A write to index 5 with data bit 0 set lowers it. A write to either index with data bit 0 clear has no effect. A read of index 4 returns raw level bit 0 in bit 0 and zero in all other bits.
- R7: `irq_o` is registered. After each clock edge it equals the OR of (raw level AND normal mask), where both values are taken as they stand after any write in that cycle.
- R8: `fiq_o` follows the same rule, using the fast-request mask.
- R9: The following accesses are bad: a read of index 3, 5, 11 or of any unmapped index; and a write to index 0, 1, 8, 9 or to any unmapped index. A bad read returns zero. A bad write changes no state. In the cycle after any bad access, `bad_o` is high for exactly one cycle. A legal access leaves `bad_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt lines |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word index of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| bad_o | output | 1 | One-cycle pulse after an illegal access |

## Verification
The bench builds the block with its defaults: 32 lines, a 32-bit data word and a 4-bit word index. With a 4-bit index, random addressing reaches all sixteen indexes. That covers the six unmapped ones and the read-only and write-only registers used in the wrong direction. With the full 32-line word, sparse random set and clear masks exercise every mask bit and the top line. Line 0 and the software latch are driven together so that both can hold bit 0 high at the same time.

// File: rtl/dual_line_intc.sv
`timescale 1ns/1ps
module dual_line_intc #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               sel,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               bad_o
);
  localparam logic [ADDR_W-1:0] IX_N_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_N_RAW  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_N_SET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_N_CLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_SW_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IX_SW_CLR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IX_F_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] IX_F_RAW  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] IX_F_SET  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] IX_F_CLR  = ADDR_W'(11);
  localparam logic [NUM_SRC-1:0] LSB = NUM_SRC'(1);

  logic [NUM_SRC-1:0] n_en_q, n_en_d, f_en_q, f_en_d;
  logic [NUM_SRC-1:0] raw_now, raw_nxt, wmask, rd_word;
  logic soft_q, soft_d, bad_d, irq_q, fiq_q, bad_q;

  wire wr_hit = sel & wr;
  wire rd_hit = sel & ~wr;

  assign wmask   = wdata[NUM_SRC-1:0];
  assign raw_now = src_lvl | (soft_q ? LSB : '0);
  assign raw_nxt = src_lvl | (soft_d ? LSB : '0);

  always_comb begin
    n_en_d = n_en_q;
    f_en_d = f_en_q;
    soft_d = soft_q;
    bad_d  = 1'b0;
    if (wr_hit) begin
      case (addr)
        IX_N_SET:  n_en_d = n_en_q | wmask;
        IX_N_CLR:  n_en_d = n_en_q & ~wmask;
        IX_F_SET:  f_en_d = f_en_q | wmask;
        IX_F_CLR:  f_en_d = f_en_q & ~wmask;
        IX_SW_SET: if (wdata[0]) soft_d = 1'b1;
        IX_SW_CLR: if (wdata[0]) soft_d = 1'b0;
        default:   bad_d = 1'b1;
      endcase
    end else if (rd_hit) begin
      case (addr)
        IX_N_STAT, IX_N_RAW, IX_N_SET, IX_SW_SET,
        IX_F_STAT, IX_F_RAW, IX_F_SET: bad_d = 1'b0;
        default: bad_d = 1'b1;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_hit) begin
      case (addr)
        IX_N_STAT: rd_word = raw_now & n_en_q;
        IX_N_RAW:  rd_word = raw_now;
        IX_N_SET:  rd_word = n_en_q;
        IX_SW_SET: rd_word = raw_now & LSB;
        IX_F_STAT: rd_word = raw_now & f_en_q;
        IX_F_RAW:  rd_word = raw_now;
        IX_F_SET:  rd_word = f_en_q;
        default:   rd_word = '0;
      endcase
    end
  end

  assign rdata = DATA_W'(rd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_en_q <= '0;
      f_en_q <= '0;
      soft_q <= 1'b0;
      irq_q  <= 1'b0;
      fiq_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      n_en_q <= n_en_d;
      f_en_q <= f_en_d;
      soft_q <= soft_d;
      irq_q  <= |(raw_nxt & n_en_d);
      fiq_q  <= |(raw_nxt & f_en_d);
      bad_q  <= bad_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/dual_line_intc_chk.sv
`timescale 1ns/1ps
module dual_line_intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_lvl,
  input logic               sel,
  input logic               wr,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               bad_o
);
  wire rd = sel && !wr;
  wire wrt = sel && wr;

  assert_clear_only_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == ADDR_W'(3) || addr == ADDR_W'(5) || addr == ADDR_W'(11))) |-> (rdata == '0));

  assert_clear_only_read_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(5)) |=> bad_o);

  assert_flag_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !bad_o);

  assert_raw_tracks_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(1)) |-> (rdata[NUM_SRC-1:1] == src_lvl[NUM_SRC-1:1]));

  assert_status_within_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(0)) |-> ((rdata[NUM_SRC-1:1] & ~src_lvl[NUM_SRC-1:1]) == '0));

  assert_soft_read_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_W'(4)) |-> (rdata[DATA_W-1:1] == '0));

  assert_full_clear_empties_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrt && addr == ADDR_W'(3) && wdata[NUM_SRC-1:0] == '1) |=>
      ((rd && addr == ADDR_W'(2)) |-> rdata == '0));

  assert_full_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrt && addr == ADDR_W'(3) && wdata[NUM_SRC-1:0] == '1) |=> !irq_o);

  assert_full_clear_drops_fiq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrt && addr == ADDR_W'(11) && wdata[NUM_SRC-1:0] == '1) |=> !fiq_o);
endmodule

bind dual_line_intc dual_line_intc_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_dual_line_intc.sv
`timescale 1ns/1ps
module test_dual_line_intc;
  localparam int NS = 32;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src_lvl = '0;
  logic sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_o, fiq_o, bad_o;

  always #2.5 clk = ~clk;

  dual_line_intc #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) i_dual_line_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .bad_o(bad_o));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] m_ie = '0, m_fe = '0;
  logic m_soft = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_raw(input logic [31:0] s);
    return s | {31'b0, m_soft};
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a, input logic [31:0] s);
    case (a)
      4'd0:  return m_raw(s) & m_ie;
      4'd1:  return m_raw(s);
      4'd2:  return m_ie;
      4'd4:  return {31'b0, m_raw(s)[0]};
      4'd8:  return m_raw(s) & m_fe;
      4'd9:  return m_raw(s);
      4'd10: return m_fe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit m_bad(input bit w, input logic [3:0] a);
    if (w) return !(a inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd10, 4'd11});
    return !(a inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd8, 4'd9, 4'd10});
  endfunction

  function automatic string rd_req(input logic [3:0] a);
    case (a)
      4'd0, 4'd8: return "R5 masked status";
      4'd1, 4'd9: return "R4 raw level";
      4'd2:       return "R2 normal mask readback";
      4'd10:      return "R3 fast mask readback";
      4'd4:       return "R6 soft readback";
      default:    return "R9 bad read data";
    endcase
  endfunction

  task automatic op(input bit w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    src_lvl = s; sel = 1'b1; wr = w; addr = a; wdata = d;
    #1;
    if (!w) check(rd_req(a), rdata, m_read(a, s));
    @(posedge clk);
    #1;
    sel = 1'b0;
    if (w) begin
      case (a)
        4'd2:  m_ie = m_ie | d;
        4'd3:  m_ie = m_ie & ~d;
        4'd10: m_fe = m_fe | d;
        4'd11: m_fe = m_fe & ~d;
        4'd4:  if (d[0]) m_soft = 1'b1;
        4'd5:  if (d[0]) m_soft = 1'b0;
        default: ;
      endcase
    end
    check("R7 irq_o", {31'b0, irq_o}, {31'b0, |(m_raw(s) & m_ie)});
    check("R8 fiq_o", {31'b0, fiq_o}, {31'b0, |(m_raw(s) & m_fe)});
    check("R9 bad_o", {31'b0, bad_o}, {31'b0, m_bad(w, a)});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq_o in reset", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o in reset", {31'b0, fiq_o}, 32'h0);
    check("R1 bad_o in reset", {31'b0, bad_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: masks and latch empty after reset
    op(0, 4'd2, 0, 0);
    op(0, 4'd10, 0, 0);
    op(0, 4'd4, 0, 0);
    // R2 set/clear and output
    op(1, 4'd2, 32'h0000_00F0, 0);
    op(0, 4'd2, 0, 0);
    op(1, 4'd3, 32'h0000_0030, 32'h0000_0020);
    op(0, 4'd0, 0, 32'h0000_0060);
    op(0, 4'd1, 0, 32'h8000_0040);
    // R3 fast mask
    op(1, 4'd10, 32'h8000_0001, 0);
    op(1, 4'd11, 32'h0000_0001, 32'h8000_0000);
    op(0, 4'd8, 0, 32'h8000_0001);
    op(0, 4'd10, 0, 0);
    // R6 soft latch
    op(1, 4'd4, 32'hFFFF_FFFE, 0);
    op(0, 4'd4, 0, 0);
    op(1, 4'd4, 32'h0000_0001, 0);
    op(0, 4'd4, 0, 0);
    op(1, 4'd2, 32'h0000_0001, 0);
    op(1, 4'd5, 32'h0000_0001, 32'h0000_0001);
    op(0, 4'd9, 0, 32'h0000_0001);
    op(1, 4'd5, 32'h0000_0001, 0);
    op(0, 4'd4, 0, 0);
    // R9 status writes ignored, bad reads
    op(1, 4'd0, 32'hFFFF_FFFF, 0);
    op(1, 4'd1, 32'hFFFF_FFFF, 0);
    op(1, 4'd8, 32'hFFFF_FFFF, 0);
    op(1, 4'd9, 32'hFFFF_FFFF, 0);
    op(0, 4'd2, 0, 0);
    op(0, 4'd10, 0, 0);
    op(0, 4'd4, 0, 0);
    op(0, 4'd3, 0, 32'hFFFF_FFFF);
    op(0, 4'd5, 0, 32'hFFFF_FFFF);
    op(0, 4'd11, 0, 32'hFFFF_FFFF);
    op(0, 4'd6, 0, 32'hFFFF_FFFF);
    op(1, 4'd15, 32'hFFFF_FFFF, 0);
    // R7 R8: full clears
    op(1, 4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    op(1, 4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d, s;
      logic [3:0] a;
      bit w;
      w = 1'($urandom % 2);
      a = 4'($urandom % 16);
      d = $urandom & $urandom & $urandom;
      s = $urandom & $urandom & $urandom;
      if (($urandom % 8) == 0) d[0] = 1'b1;
      op(w, a, d, s);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule